// File: doc/BRIEF.md
# Flow-Controlled Serial Byte Transmitter

This block turns a stream of bytes into an asynchronous serial line. Each byte goes out as one start bit, eight data bits and one stop bit. Every bit lasts a fixed number of oversample ticks, which arrive on a strobe input from an external rate generator. Bytes come from a transmit queue through a valid/ready pair. A byte is taken in the same cycle that the block raises its ready output while the queue holds valid data.

Flow control can be switched on. When it is on, the block starts a byte only while the active-low clear-to-send input is asserted. Whether the next byte may follow straight on is decided once per frame, at the midpoint of the stop bit. A byte that has already started always finishes. When flow control is off, every queued byte is sent whatever the clear-to-send level, and any change on that input sets a sticky flag that the host clears. A diagnostic loopback mode steers the serial stream to the receive-side input and holds the external line at its idle level.

Top module: `uart_cts_tx`

## Requirements
- R1: After synchronous reset, `txd` is high, `cts_irq` is low and no byte is in flight.
- R2: A frame is one low start bit, then the eight data bits least significant bit first, then one high stop bit. Each bit lasts OVS (default 16) `baud_tick` pulses. A new frame begins counting in the cycle after its byte is accepted.
- R3: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. When the engine is idle, `in_ready` is high if `flow_en` is low or `cts_n` is low. While a frame is in flight, `in_ready` is high only during the final tick of the stop bit, and only if the permission for back-to-back sending allows it.
- R4: While the engine is idle, `flow_en` is high and `cts_n` is high, no byte is accepted and `txd` stays high.
- R5: With `flow_en` high, `cts_n` is sampled on the tick that completes the 8th of the 16 oversample periods of the stop bit. If it is low there, a waiting byte starts directly after that stop bit, even if `cts_n` rises later in the stop bit.
- R6: If `cts_n` is high at that stop-bit sample, the current frame still completes. The next byte waits while idle until `cts_n` goes low, and then starts.
- R7: With `flow_en` low, any change of `cts_n` between two consecutive cycles sets `cts_irq` on the following edge. `cts_irq` stays set until `irq_clr` is high, and a new change wins over a clear in the same cycle.
- R8: With `flow_en` high, changes of `cts_n` never set `cts_irq`.
- R9: With `flow_en` low, queued bytes are sent back to back whatever the level of `cts_n`.
- R10: With `loop_en` high, `txd` is held high and `rx_to_rcv` carries the serial stream. With `loop_en` low, `rx_to_rcv` follows `rxd_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | Oversample strobe, one clock wide |
| in_data | input | DW | Byte from the transmit queue |
| in_valid | input | 1 | Queue holds a byte |
| in_ready | output | 1 | Byte is taken this cycle when valid |
| cts_n | input | 1 | Clear-to-send, active low |
| flow_en | input | 1 | Enables gating on clear-to-send |
| loop_en | input | 1 | Diagnostic loopback enable |
| irq_clr | input | 1 | Clears the sticky change flag |
| rxd_pin | input | 1 | External receive line |
| txd | output | 1 | External serial transmit line |
| rx_to_rcv | output | 1 | Receive-side input: `rxd_pin`, or the serial stream in loopback |
| cts_irq | output | 1 | Sticky clear-to-send change flag |

## Verification
`in_ready` is combinational and is due in the same cycle as the inputs that form it. The line level changes one clock after the edge that accepts a byte or that carries the tick ending a bit. The change flag rises one clock after the cycle in which `cts_n` differs from its previous value. The bench drives inputs and compares every output with a tick-counting reference model at each falling edge, so registered results are read one full edge after their cause. The stop-bit decision is tested by changing `cts_n` just before and just after the sample tick, with the timing taken from the model's own tick count.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    // Line level driven for a given frame phase.
    function automatic logic line_level(input tx_state_e st, input logic lsb);
        case (st)
            TX_START: return 1'b0;
            TX_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/txf_serializer.sv
module txf_serializer
    import uart_txf_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    input  logic          go_idle,
    input  logic          go_next,
    output logic          in_ready,
    output logic          mid_stop,
    output logic          ser,
    output tx_state_e     st
);
    localparam int SUBW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BITW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVS - 1);
    localparam logic [SUBW-1:0] SUB_MID  = SUBW'(OVS / 2 - 1);
    localparam logic [BITW-1:0] BIT_LAST = BITW'(DW - 1);

    logic [SUBW-1:0] sub;
    logic [BITW-1:0] bidx;
    logic [DW-1:0]   sh;
    logic            last_sub;
    logic            accept;

    assign last_sub = (sub == SUB_LAST);

    always_comb begin
        case (st)
            TX_IDLE: in_ready = go_idle;
            TX_STOP: in_ready = tick && last_sub && go_next;
            default: in_ready = 1'b0;
        endcase
    end

    assign accept   = in_valid && in_ready;
    assign mid_stop = (st == TX_STOP) && tick && (sub == SUB_MID);
    assign ser      = line_level(st, sh[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            sub  <= '0;
            bidx <= '0;
            sh   <= '0;
        end else if (accept) begin
            st   <= TX_START;
            sub  <= '0;
            bidx <= '0;
            sh   <= in_data;
        end else if (tick && st != TX_IDLE) begin
            if (last_sub) begin
                sub <= '0;
                case (st)
                    TX_START: st <= TX_DATA;
                    TX_DATA: begin
                        sh <= {1'b0, sh[DW-1:1]};
                        if (bidx == BIT_LAST) begin
                            st <= TX_STOP;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    default: st <= TX_IDLE;
                endcase
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/txf_flow_gate.sv
module txf_flow_gate (
    input  logic clk,
    input  logic rst,
    input  logic cts_n,
    input  logic flow_en,
    input  logic mid_stop,
    input  logic irq_clr,
    output logic go_idle,
    output logic go_next,
    output logic cts_irq
);
    logic cts_q;
    logic grant;

    assign go_idle = !flow_en || !cts_n;
    assign go_next = !flow_en || grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_q   <= cts_n;
            grant   <= 1'b0;
            cts_irq <= 1'b0;
        end else begin
            cts_q <= cts_n;
            if (mid_stop) begin
                grant <= !cts_n;
            end
            if (!flow_en && (cts_n != cts_q)) begin
                cts_irq <= 1'b1;
            end else if (irq_clr) begin
                cts_irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txf_line_mux.sv
module txf_line_mux (
    input  logic loop_en,
    input  logic ser,
    input  logic rxd_pin,
    output logic txd,
    output logic rx_to_rcv
);
    assign txd       = loop_en ? 1'b1 : ser;
    assign rx_to_rcv = loop_en ? ser  : rxd_pin;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_txf_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          cts_n,
    input  logic          flow_en,
    input  logic          loop_en,
    input  logic          irq_clr,
    input  logic          rxd_pin,
    output logic          txd,
    output logic          rx_to_rcv,
    output logic          cts_irq
);
    logic      go_idle;
    logic      go_next;
    logic      mid_stop;
    logic      ser;
    tx_state_e st;

    txf_serializer #(.DW(DW), .OVS(OVS)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .in_data  (in_data),
        .in_valid (in_valid),
        .go_idle  (go_idle),
        .go_next  (go_next),
        .in_ready (in_ready),
        .mid_stop (mid_stop),
        .ser      (ser),
        .st       (st)
    );

    txf_flow_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .cts_n    (cts_n),
        .flow_en  (flow_en),
        .mid_stop (mid_stop),
        .irq_clr  (irq_clr),
        .go_idle  (go_idle),
        .go_next  (go_next),
        .cts_irq  (cts_irq)
    );

    txf_line_mux u_mux (
        .loop_en   (loop_en),
        .ser       (ser),
        .rxd_pin   (rxd_pin),
        .txd       (txd),
        .rx_to_rcv (rx_to_rcv)
    );
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk
    import uart_txf_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      flow_en,
    input logic      cts_n,
    input logic      loop_en,
    input logic      irq_clr,
    input logic      in_ready,
    input logic      txd,
    input logic      cts_irq,
    input logic      ser,
    input tx_state_e st
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (txd && !cts_irq));

    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        (st == TX_START) |-> !ser);

    a_r2_stop_high: assert property (@(posedge clk) disable iff (rst)
        (st == TX_STOP) |-> ser);

    a_r3_ready_phase: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (st == TX_IDLE || st == TX_STOP));

    a_r4_blocked: assert property (@(posedge clk) disable iff (rst)
        (flow_en && cts_n && st == TX_IDLE) |-> !in_ready);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (cts_irq && !irq_clr) |=> cts_irq);

    a_r8_no_flag: assert property (@(posedge clk) disable iff (rst)
        (flow_en && !cts_irq) |=> !cts_irq);

    a_r10_loop_idle: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> txd);
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .flow_en  (flow_en),
    .cts_n    (cts_n),
    .loop_en  (loop_en),
    .irq_clr  (irq_clr),
    .in_ready (in_ready),
    .txd      (txd),
    .cts_irq  (cts_irq),
    .ser      (ser),
    .st       (st)
);

// File: tb/uart_cts_tx_tb.sv
`timescale 1ns/1ps
module uart_cts_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       cts_n = 1'b1;
    logic       flow_en = 1'b0;
    logic       loop_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       rxd_pin = 1'b1;
    logic       txd;
    logic       rx_to_rcv;
    logic       cts_irq;

    always #2.5 clk = ~clk;

    uart_cts_tx u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .cts_n(cts_n),
        .flow_en(flow_en), .loop_en(loop_en), .irq_clr(irq_clr),
        .rxd_pin(rxd_pin), .txd(txd), .rx_to_rcv(rx_to_rcv), .cts_irq(cts_irq)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [7:0] srcq[$];

    // Reference model: tick count within a 160-tick frame
    bit         m_busy = 0;
    int         m_tc = 0;
    logic [7:0] m_data = 8'h00;
    bit         m_grant = 0;
    bit         m_irq = 0;
    logic       m_ctsq = 1'b1;

    function automatic logic m_line();
        if (!m_busy) return 1'b1;
        if (m_tc < 16) return 1'b0;
        if (m_tc < 144) return m_data[m_tc / 16 - 1];
        return 1'b1;
    endfunction

    function automatic logic m_ready();
        if (!m_busy) return !flow_en || !cts_n;
        return baud_tick && (m_tc == 159) && (!flow_en || m_grant);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_tc = 0; m_grant = 0; m_irq = 0; m_ctsq = cts_n;
        end else begin
            bit acc;
            acc = in_valid && m_ready();
            if (!flow_en && cts_n != m_ctsq) m_irq = 1;
            else if (irq_clr) m_irq = 0;
            m_ctsq = cts_n;
            if (acc) begin
                m_data = in_data;
                void'(srcq.pop_front());
                m_busy = 1;
                m_tc = 0;
            end else if (m_busy && baud_tick) begin
                if (m_tc == 151) m_grant = !cts_n;
                if (m_tc == 159) m_busy = 0;
                else m_tc++;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        baud_tick = (cyc % 2 == 0);
        in_valid  = (srcq.size() != 0);
        in_data   = in_valid ? srcq[0] : 8'h00;
        #1;
        if (!rst) begin
            chk("R2 txd", txd, loop_en ? 1 : m_line());
            chk("R10 rx_to_rcv", rx_to_rcv, loop_en ? m_line() : rxd_pin);
            chk("R3 in_ready", in_ready, m_ready());
            chk("R7 cts_irq", cts_irq, m_irq);
        end
    end

    task automatic wait_tc(input int n);
        do @(negedge clk); while (!(m_busy && m_tc == n));
        #2;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || srcq.size() != 0);
        #2;
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk("R1 txd idle", txd, 1);
        chk("R1 flag low", cts_irq, 0);

        // R9 / R2 / R7: flow off, cts inactive, two bytes back to back
        srcq.push_back(8'hA5); srcq.push_back(8'h3C);
        wait_tc(40);
        chk("R2 data bit1 of A5", txd, 0);
        wait_tc(136);
        chk("R2 data bit7 of A5", txd, 1);
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk); @(negedge clk); #2;
        chk("R7 flag set on edge", cts_irq, 1);
        wait_idle();
        chk("R9 queue drained despite cts", srcq.size(), 0);
        pulse_clr();
        @(negedge clk); #2;
        chk("R7 flag cleared", cts_irq, 0);

        // R4 / R8: flow on, cts inactive blocks start
        @(negedge clk); flow_en = 1'b1;
        @(negedge clk); cts_n = 1'b1;
        srcq.push_back(8'h81); srcq.push_back(8'h7E);
        repeat (100) @(negedge clk); #2;
        chk("R4 line idle while blocked", txd, 1);
        chk("R4 nothing taken", srcq.size(), 2);
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk); #2;
        chk("R3 start after cts low", txd, 0);

        // R5: cts rises after the stop-bit sample
        wait_tc(153);
        cts_n = 1'b1;
        do @(negedge clk); while (m_busy && m_tc >= 153);
        #2;
        chk("R5 next frame start bit", txd, 0);
        chk("R5 queue empty", srcq.size(), 0);
        wait_idle();

        // R6: cts rises before the stop-bit sample
        @(negedge clk); cts_n = 1'b0;
        srcq.push_back(8'h55); srcq.push_back(8'hC3);
        wait_tc(140);
        cts_n = 1'b1;
        do @(negedge clk); while (m_busy);
        repeat (50) @(negedge clk); #2;
        chk("R6 held after frame", txd, 1);
        chk("R6 byte waiting", srcq.size(), 1);
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk); #2;
        chk("R6 resumes on cts low", txd, 0);
        chk("R8 no flag under flow", cts_irq, 0);
        wait_idle();

        // R10: loopback
        @(negedge clk); flow_en = 1'b0; loop_en = 1'b1; rxd_pin = 1'b0;
        srcq.push_back(8'h0F);
        wait_tc(8);
        chk("R10 loop start bit", rx_to_rcv, 0);
        chk("R10 line held high", txd, 1);
        wait_tc(20);
        chk("R10 loop data bit0", rx_to_rcv, 1);
        wait_tc(90);
        chk("R10 loop data bit4", rx_to_rcv, 0);
        wait_idle();
        @(negedge clk); loop_en = 1'b0;
        @(negedge clk); #2;
        chk("R10 pin passthrough low", rx_to_rcv, 0);
        @(negedge clk); rxd_pin = 1'b1;
        @(negedge clk); #2;
        chk("R10 pin passthrough high", rx_to_rcv, 1);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule